// File: doc/BRIEF.md
# Display Controller Interrupt Status and Mask Unit

This unit collects the event pulses of a multi-channel display controller and turns them into readable status and one interrupt line. Each fetch channel reports start-of-frame, end-of-frame, branch taken, bus error and input underrun as one-cycle pulses. Channel 0 lands in a global status register. Channels 1 and up land in a per-channel status register, where each event kind owns a lane of eight bits. A second group of controller-wide events is recorded in the global register: output underrun, read-status, command, overlay underrun and address-bias. The unit also holds the enable and the stop-after-frame control bits, so it can report a quick disable and a last-frame-done.

Software reads the status, masks and interrupt-ID register over a simple register bus and clears status by writing ones. An unmasked frame or branch event, or any bus error, raises a summary bit and captures that channel's frame ID. The interrupt line is the registered OR of every unmasked status bit.

Top module: `lcd_irq_unit`

## Requirements
- R1: After reset the global and per-channel status, the interrupt-ID register, the enable and stop bits and the interrupt line are all zero, the global mask reads 0x1FFF and the per-channel mask reads 0x3F3F3F3F.
- R2: Channel 0 events set global status bits: start-of-frame bit 1, end-of-frame bit 8, branch bit 9, input underrun bit 4. Start-of-frame and end-of-frame are recorded only while that channel's sof_en_i or eof_en_i bit is high.
- R3: For channel n of 1 to 6, start-of-frame sets per-channel bit n-1, end-of-frame bit n+7, branch bit n+15 and input underrun bit n+23, under the same enable gating as R2.
- R4: A recorded start-of-frame, end-of-frame or branch event whose mask bit is clear sets global bit 10 (summary) and loads that channel's frame ID into the interrupt-ID register. Channel 0 uses global mask bits 1, 8 and 9, and channel n uses per-channel mask bits at its own status positions. A masked event does neither. If several channels load in one cycle, the highest-numbered channel wins.
- R5: A bus error on any channel always sets global bit 2 and the summary bit 10 and loads that channel's frame ID. It also writes the channel number into global bits 30:28, and the highest channel wins on a tie.
- R6: A write to the global status register clears the bits among 11:0 that are written as one; bit 12 is never cleared. Clearing bit 2 also zeroes bits 30:28.
- R7: A write to the per-channel status register clears only the written-one bits that fall inside 0x003E3F3F.
- R8: Writing the control register with bit 0 low while enable is high sets global bit 7 (quick disable). Raising enable does not set it.
- R9: A frame_done_i pulse while enable and stop-after-frame (control bit 1) are both high clears enable and sets global bit 0. With stop-after-frame low, enable is kept.
- R10: irq_o is high one cycle after any status bit is set whose mask bit is clear, and low one cycle after no such bit remains.
- R11: When an event sets a status bit in the same cycle as a write that clears it, the bit ends set.
- R12: ctrl_evt_i bit 0 sets global bit 3, bit 1 sets bit 5, bit 2 sets bit 6, bit 3 sets bit 11 and bit 4 sets bit 12.
- R13: The registers sit at these addresses: control 0, global mask 1, per-channel mask 2, global status 3, per-channel status 4, interrupt ID 5. Read data appears one cycle after reg_rd_i. Mask writes keep only bits 12:0 (global) and 0x3F3F3F3F (per-channel). Writes to the interrupt ID and reads of unused addresses have no effect and return zero respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| sof_evt_i | input | NCH | Start-of-frame pulse per channel |
| eof_evt_i | input | NCH | End-of-frame pulse per channel |
| brs_evt_i | input | NCH | Branch-taken pulse per channel |
| ber_evt_i | input | NCH | Bus-error pulse per channel |
| iu_evt_i | input | NCH | Input-underrun pulse per channel |
| sof_en_i | input | NCH | Channel command enables start-of-frame reporting |
| eof_en_i | input | NCH | Channel command enables end-of-frame reporting |
| frame_id_i | input | NCH*IDW | Current frame ID of each channel, channel c at bits c*IDW upward |
| frame_done_i | input | 1 | Frame completed pulse |
| ctrl_evt_i | input | 5 | Controller-wide event pulses (encoding in R12) |
| enable_o | output | 1 | Current enable bit |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
Two functions can fall in the same cycle: an event setting a status bit and a software write clearing it. The bench provokes this by driving an end-of-frame pulse on channel 0 in the cycle of a write-one-to-clear of bit 8, and it expects bit 8 to remain set. It also fires end-of-frame on two unmasked channels at once and expects the interrupt ID to hold the higher channel's frame ID. It fires bus errors on two channels at once and expects bits 30:28 to hold the higher channel number.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  // register bus
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_GMASK = 3'd1;
  localparam logic [REG_AW-1:0] A_PMASK = 3'd2;
  localparam logic [REG_AW-1:0] A_GSTAT = 3'd3;
  localparam logic [REG_AW-1:0] A_PSTAT = 3'd4;
  localparam logic [REG_AW-1:0] A_INTID = 3'd5;

  // global status layout (software-visible positions)
  localparam int GSW      = 13;
  localparam int GS_LDD   = 0;
  localparam int GS_SOF   = 1;
  localparam int GS_BER   = 2;
  localparam int GS_ABC   = 3;
  localparam int GS_IU0   = 4;
  localparam int GS_IU1   = 5;
  localparam int GS_OU    = 6;
  localparam int GS_QD    = 7;
  localparam int GS_EOF   = 8;
  localparam int GS_BS    = 9;
  localparam int GS_SINT  = 10;
  localparam int GS_RDST  = 11;
  localparam int GS_CMD   = 12;
  localparam int BCH_W    = 3;

  // per-channel lanes: bit = lane base + (channel - 1)
  localparam int LANE_SOF = 0;
  localparam int LANE_EOF = 8;
  localparam int LANE_BS  = 16;
  localparam int LANE_IU  = 24;

  // clear and write masks
  localparam logic [GSW-1:0] GCLR_MASK = 13'h0FFF;
  localparam logic [31:0]    PCLR_MASK = 32'h003E_3F3F;
  localparam logic [31:0]    PMASK_WR  = 32'h3F3F_3F3F;

  // control register bits
  localparam int CTL_EN   = 0;
  localparam int CTL_STOP = 1;

  // controller-wide event encoding
  localparam int CE_ABC  = 0;
  localparam int CE_IU1  = 1;
  localparam int CE_OU   = 2;
  localparam int CE_RDST = 3;
  localparam int CE_CMD  = 4;
  localparam int CE_W    = 5;
endpackage

// File: rtl/lcd_evt_map.sv
module lcd_evt_map
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int IDW = 32
) (
  input  logic [NCH-1:0]     sof_i,
  input  logic [NCH-1:0]     eof_i,
  input  logic [NCH-1:0]     brs_i,
  input  logic [NCH-1:0]     ber_i,
  input  logic [NCH-1:0]     iu_i,
  input  logic [NCH-1:0]     sof_en_i,
  input  logic [NCH-1:0]     eof_en_i,
  input  logic [NCH-1:0]     msk_sof_i,
  input  logic [NCH-1:0]     msk_eof_i,
  input  logic [NCH-1:0]     msk_bs_i,
  input  logic [NCH*IDW-1:0] fid_i,
  output logic [GSW-1:0]     gset_o,
  output logic [31:0]        pset_o,
  output logic               id_load_o,
  output logic [IDW-1:0]     id_val_o,
  output logic               ber_hit_o,
  output logic [BCH_W-1:0]   ber_ch_o
);
  logic [NCH-1:0][GSW-1:0] g_c;
  logic [NCH-1:0][31:0]    p_c;
  logic [NCH-1:0]          ld_c;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sof_ok, eof_ok;
    assign sof_ok  = sof_i[c] & sof_en_i[c];
    assign eof_ok  = eof_i[c] & eof_en_i[c];
    assign ld_c[c] = (sof_ok & ~msk_sof_i[c]) | (eof_ok & ~msk_eof_i[c])
                   | (brs_i[c] & ~msk_bs_i[c]) | ber_i[c];
    if (c == 0) begin : g_glb
      assign g_c[c] = (GSW'(sof_ok) << GS_SOF) | (GSW'(eof_ok) << GS_EOF)
                    | (GSW'(brs_i[c]) << GS_BS) | (GSW'(iu_i[c]) << GS_IU0);
      assign p_c[c] = '0;
    end else begin : g_lane
      assign g_c[c] = '0;
      assign p_c[c] = (32'(sof_ok) << (c - 1 + LANE_SOF))
                    | (32'(eof_ok) << (c - 1 + LANE_EOF))
                    | (32'(brs_i[c]) << (c - 1 + LANE_BS))
                    | (32'(iu_i[c]) << (c - 1 + LANE_IU));
    end
  end

  // merge lanes; ascending scan lets the highest channel win ties
  always_comb begin
    gset_o   = '0;
    pset_o   = '0;
    id_val_o = '0;
    ber_ch_o = '0;
    for (int c = 0; c < NCH; c++) begin
      gset_o = gset_o | g_c[c];
      pset_o = pset_o | p_c[c];
      if (ld_c[c]) id_val_o = fid_i[c*IDW +: IDW];
      if (ber_i[c]) ber_ch_o = BCH_W'(c);
    end
    gset_o[GS_BER]  = |ber_i;
    gset_o[GS_SINT] = |ld_c;
    id_load_o       = |ld_c;
    ber_hit_o       = |ber_i;
  end
endmodule

// File: rtl/lcd_irq_regs.sv
module lcd_irq_regs
  import lcd_irq_pkg::*;
#(
  parameter int IDW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [GSW-1:0]    gset_i,
  input  logic [31:0]       pset_i,
  input  logic              id_load_i,
  input  logic [IDW-1:0]    id_val_i,
  input  logic              ber_hit_i,
  input  logic [BCH_W-1:0]  ber_ch_i,
  input  logic              frame_done_i,
  input  logic [CE_W-1:0]   ctrl_evt_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              en_o,
  output logic              stop_o,
  output logic [GSW-1:0]    gstat_o,
  output logic [31:0]       pstat_o,
  output logic [GSW-1:0]    gmask_o,
  output logic [31:0]       pmask_o
);
  logic [GSW-1:0]   gstat_q, gstat_d, gmask_q, gmask_d, gclr, ev_set;
  logic [31:0]      pstat_q, pstat_d, pmask_q, pmask_d, pclr, rdata_d;
  logic [BCH_W-1:0] bch_q, bch_d;
  logic [IDW-1:0]   id_q, id_d;
  logic             en_q, en_d, stop_q, stop_d, irq_q, irq_d;
  logic             wr_ctrl, qd_set, ldd_set;

  always_comb begin
    wr_ctrl = wr_i && (addr_i == A_CTRL);
    gclr    = (wr_i && addr_i == A_GSTAT) ? (wdata_i[GSW-1:0] & GCLR_MASK) : '0;
    pclr    = (wr_i && addr_i == A_PSTAT) ? (wdata_i & PCLR_MASK) : '0;
    qd_set  = wr_ctrl && en_q && !wdata_i[CTL_EN];
    ldd_set = frame_done_i && en_q && stop_q;

    ev_set           = gset_i;
    ev_set[GS_ABC]   = gset_i[GS_ABC]  | ctrl_evt_i[CE_ABC];
    ev_set[GS_IU1]   = gset_i[GS_IU1]  | ctrl_evt_i[CE_IU1];
    ev_set[GS_OU]    = gset_i[GS_OU]   | ctrl_evt_i[CE_OU];
    ev_set[GS_RDST]  = gset_i[GS_RDST] | ctrl_evt_i[CE_RDST];
    ev_set[GS_CMD]   = gset_i[GS_CMD]  | ctrl_evt_i[CE_CMD];
    ev_set[GS_QD]    = gset_i[GS_QD]   | qd_set;
    ev_set[GS_LDD]   = gset_i[GS_LDD]  | ldd_set;

    // set wins over clear
    gstat_d = (gstat_q & ~gclr) | ev_set;
    pstat_d = (pstat_q & ~pclr) | pset_i;
    if (ber_hit_i)          bch_d = ber_ch_i;
    else if (gclr[GS_BER])  bch_d = '0;
    else                    bch_d = bch_q;

    en_d   = wr_ctrl ? wdata_i[CTL_EN] : (ldd_set ? 1'b0 : en_q);
    stop_d = wr_ctrl ? wdata_i[CTL_STOP] : stop_q;
    gmask_d = (wr_i && addr_i == A_GMASK) ? wdata_i[GSW-1:0] : gmask_q;
    pmask_d = (wr_i && addr_i == A_PMASK) ? (wdata_i & PMASK_WR) : pmask_q;
    id_d    = id_load_i ? id_val_i : id_q;

    rdata_d = '0;
    if (rd_i) begin
      case (addr_i)
        A_CTRL:  rdata_d = 32'({stop_q, en_q});
        A_GMASK: rdata_d = 32'(gmask_q);
        A_PMASK: rdata_d = pmask_q;
        A_GSTAT: rdata_d = {1'b0, bch_q, {(28 - GSW){1'b0}}, gstat_q};
        A_PSTAT: rdata_d = pstat_q;
        A_INTID: rdata_d[IDW-1:0] = id_q;
        default: rdata_d = '0;
      endcase
    end

    irq_d = (|(gstat_q & ~gmask_q)) | (|(pstat_q & ~pmask_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gstat_q <= '0;
      pstat_q <= '0;
      gmask_q <= '1;
      pmask_q <= PMASK_WR;
      bch_q   <= '0;
      id_q    <= '0;
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      gstat_q <= gstat_d;
      pstat_q <= pstat_d;
      gmask_q <= gmask_d;
      pmask_q <= pmask_d;
      bch_q   <= bch_d;
      id_q    <= id_d;
      en_q    <= en_d;
      stop_q  <= stop_d;
      irq_q   <= irq_d;
      if (rd_i) rdata_o <= rdata_d;
    end
  end

  assign irq_o   = irq_q;
  assign en_o    = en_q;
  assign stop_o  = stop_q;
  assign gstat_o = gstat_q;
  assign pstat_o = pstat_q;
  assign gmask_o = gmask_q;
  assign pmask_o = pmask_q;

  // R11
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (gset_i[GS_EOF] && gclr[GS_EOF]) |=> gstat_q[GS_EOF]);

  // R5
  ber_field_chk: assert property (@(posedge clk) disable iff (rst)
    ber_hit_i |=> (bch_q == $past(ber_ch_i)));
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int IDW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NCH-1:0]       sof_evt_i,
  input  logic [NCH-1:0]       eof_evt_i,
  input  logic [NCH-1:0]       brs_evt_i,
  input  logic [NCH-1:0]       ber_evt_i,
  input  logic [NCH-1:0]       iu_evt_i,
  input  logic [NCH-1:0]       sof_en_i,
  input  logic [NCH-1:0]       eof_en_i,
  input  logic [NCH*IDW-1:0]   frame_id_i,
  input  logic                 frame_done_i,
  input  logic [4:0]           ctrl_evt_i,
  output logic                 enable_o,
  output logic                 irq_o
);
  logic [GSW-1:0]   gset, gstat, gmask;
  logic [31:0]      pset, pstat, pmask;
  logic             id_load, ber_hit, stop;
  logic [IDW-1:0]   id_val;
  logic [BCH_W-1:0] ber_ch;
  logic [NCH-1:0]   msk_sof, msk_eof, msk_bs;

  // pick each channel's mask bits from the register that holds its status
  for (genvar c = 0; c < NCH; c++) begin : g_msk
    if (c == 0) begin : g_m0
      assign msk_sof[c] = gmask[GS_SOF];
      assign msk_eof[c] = gmask[GS_EOF];
      assign msk_bs[c]  = gmask[GS_BS];
    end else begin : g_mn
      assign msk_sof[c] = pmask[c - 1 + LANE_SOF];
      assign msk_eof[c] = pmask[c - 1 + LANE_EOF];
      assign msk_bs[c]  = pmask[c - 1 + LANE_BS];
    end
  end

  lcd_evt_map #(.NCH(NCH), .IDW(IDW)) u_map (
    .sof_i(sof_evt_i), .eof_i(eof_evt_i), .brs_i(brs_evt_i),
    .ber_i(ber_evt_i), .iu_i(iu_evt_i),
    .sof_en_i(sof_en_i), .eof_en_i(eof_en_i),
    .msk_sof_i(msk_sof), .msk_eof_i(msk_eof), .msk_bs_i(msk_bs),
    .fid_i(frame_id_i),
    .gset_o(gset), .pset_o(pset),
    .id_load_o(id_load), .id_val_o(id_val),
    .ber_hit_o(ber_hit), .ber_ch_o(ber_ch)
  );

  lcd_irq_regs #(.IDW(IDW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .gset_i(gset), .pset_i(pset),
    .id_load_i(id_load), .id_val_i(id_val),
    .ber_hit_i(ber_hit), .ber_ch_i(ber_ch),
    .frame_done_i(frame_done_i), .ctrl_evt_i(ctrl_evt_i),
    .rdata_o(reg_rdata_o), .irq_o(irq_o), .en_o(enable_o), .stop_o(stop),
    .gstat_o(gstat), .pstat_o(pstat), .gmask_o(gmask), .pmask_o(pmask)
  );

  // R2
  ch0_eof_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (eof_evt_i[0] && eof_en_i[0]) |=> gstat[GS_EOF]);

  // R2
  sof_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!gstat[GS_SOF] && !(sof_evt_i[0] && sof_en_i[0])) |=> !gstat[GS_SOF]);

  // R5
  ber_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|ber_evt_i) |=> (gstat[GS_BER] && gstat[GS_SINT]));

  // R8
  quick_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == A_CTRL && !reg_wdata_i[CTL_EN] && enable_o)
      |=> gstat[GS_QD]);

  // R9
  stop_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done_i && enable_o && stop && !(reg_wr_i && reg_addr_i == A_CTRL))
      |=> (!enable_o && gstat[GS_LDD]));

  // R6
  ldd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == A_GSTAT && reg_wdata_i[GS_LDD]
      && !(frame_done_i && enable_o && stop)) |=> !gstat[GS_LDD]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (((gstat & ~gmask) == '0) && ((pstat & ~pmask) == '0)) |=> !irq_o);
endmodule

// File: tb/sim_lcd_irq_unit.sv
module sim_lcd_irq_unit;
  localparam int NCH = 7;
  localparam int IDW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] sof = '0, eof = '0, brs = '0, ber = '0, iu = '0;
  logic [NCH-1:0] sof_en = '0, eof_en = '0;
  logic [NCH*IDW-1:0] fid;
  logic frame_done = 1'b0;
  logic [4:0] cev = '0;
  logic enable, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  initial for (int k = 0; k < NCH; k++) fid[k*IDW +: IDW] = 32'hA000_0000 + k;

  lcd_irq_unit #(.NCH(NCH), .IDW(IDW)) u0 (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sof_evt_i(sof), .eof_evt_i(eof), .brs_evt_i(brs), .ber_evt_i(ber),
    .iu_evt_i(iu), .sof_en_i(sof_en), .eof_en_i(eof_en), .frame_id_i(fid),
    .frame_done_i(frame_done), .ctrl_evt_i(cev), .enable_o(enable), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic fire(input logic [6:0] s, e, b, r, u, input logic [4:0] cv, input logic fd);
    @(negedge clk); sof = s; eof = e; brs = b; ber = r; iu = u; cev = cv; frame_done = fd;
    @(negedge clk); sof = '0; eof = '0; brs = '0; ber = '0; iu = '0; cev = '0; frame_done = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 gstat", 3'd3, 32'h0);
    rd_chk("R1 pstat", 3'd4, 32'h0);
    rd_chk("R1 gmask", 3'd1, 32'h1FFF);
    rd_chk("R1 pmask", 3'd2, 32'h3F3F3F3F);
    rd_chk("R1 intid", 3'd5, 32'h0);
    rd_chk("R1 ctrl", 3'd0, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 enable", 32'(enable), 32'h0);
  endtask

  task automatic t_ch0;
    fire(7'h01, 7'h0, 7'h0, 7'h0, 7'h0, 5'h0, 1'b0);
    rd_chk("R2 sof ignored without enable", 3'd3, 32'h0);
    sof_en = '1; eof_en = '1;
    fire(7'h01, 7'h01, 7'h01, 7'h0, 7'h01, 5'h0, 1'b0);
    rd_chk("R2 ch0 global bits", 3'd3, 32'h312);
    rd_chk("R4 masked no id load", 3'd5, 32'h0);
    wr(3'd3, 32'hFFF);
    rd_chk("R6 global clear", 3'd3, 32'h0);
  endtask

  task automatic t_lanes;
    fire(7'h08, 7'h08, 7'h08, 7'h0, 7'h08, 5'h0, 1'b0);
    rd_chk("R3 ch3 lanes", 3'd4, 32'h04040404);
    fire(7'h0, 7'h0, 7'h02, 7'h0, 7'h0, 5'h0, 1'b0);
    rd_chk("R3 ch1 branch lane", 3'd4, 32'h04050404);
    wr(3'd4, 32'hFFFFFFFF);
    rd_chk("R7 per-channel clear mask", 3'd4, 32'h04010000);
  endtask

  task automatic t_sint;
    wr(3'd1, 32'h1EFF);
    fire(7'h0, 7'h01, 7'h0, 7'h0, 7'h0, 5'h0, 1'b0);
    chk("R10 irq not yet", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R10 irq one cycle later", 32'(irq), 32'h1);
    rd_chk("R4 sint set", 3'd3, 32'h500);
    rd_chk("R4 id loaded ch0", 3'd5, 32'hA0000000);
    wr(3'd3, 32'hFFF);
    chk("R10 irq still high", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R10 irq drops", 32'(irq), 32'h0);
    wr(3'd1, 32'h1FFF);
    fire(7'h0, 7'h04, 7'h0, 7'h0, 7'h0, 5'h0, 1'b0);
    rd_chk("R4 masked ch2 no sint", 3'd3, 32'h0);
    rd_chk("R4 masked ch2 no id", 3'd5, 32'hA0000000);
    wr(3'd2, 32'h3F3F2D3F);
    @(negedge clk);
    chk("R10 unmask raises irq", 32'(irq), 32'h1);
    fire(7'h0, 7'h24, 7'h0, 7'h0, 7'h0, 5'h0, 1'b0);
    rd_chk("R4 highest channel id", 3'd5, 32'hA0000005);
    rd_chk("R4 sint channel", 3'd3, 32'h400);
    wr(3'd4, 32'h1200);
    rd_chk("R7 lane clear", 3'd4, 32'h04010000);
    wr(3'd3, 32'h400);
    wr(3'd2, 32'h3F3F3F3F);
    @(negedge clk);
    chk("R10 quiet", 32'(irq), 32'h0);
  endtask

  task automatic t_ber;
    fire(7'h0, 7'h0, 7'h0, 7'h48, 7'h0, 5'h0, 1'b0);
    rd_chk("R5 ber status and field", 3'd3, 32'h60000404);
    rd_chk("R5 ber id", 3'd5, 32'hA0000006);
    wr(3'd3, 32'h4);
    rd_chk("R6 ber clear field", 3'd3, 32'h400);
    wr(3'd3, 32'h400);
    rd_chk("R6 sint clear", 3'd3, 32'h0);
  endtask

  task automatic t_qd;
    wr(3'd0, 32'h1);
    chk("R8 enable up", 32'(enable), 32'h1);
    rd_chk("R8 no qd on rise", 3'd3, 32'h0);
    wr(3'd0, 32'h0);
    chk("R8 enable down", 32'(enable), 32'h0);
    rd_chk("R8 qd set", 3'd3, 32'h80);
    wr(3'd3, 32'h80);
  endtask

  task automatic t_stop;
    wr(3'd0, 32'h1);
    fire(7'h0, 7'h0, 7'h0, 7'h0, 7'h0, 5'h0, 1'b1);
    chk("R9 no stop keeps enable", 32'(enable), 32'h1);
    rd_chk("R9 no ldd", 3'd3, 32'h0);
    wr(3'd0, 32'h3);
    fire(7'h0, 7'h0, 7'h0, 7'h0, 7'h0, 5'h0, 1'b1);
    chk("R9 stop clears enable", 32'(enable), 32'h0);
    rd_chk("R9 ldd set", 3'd3, 32'h1);
    rd_chk("R13 ctrl readback", 3'd0, 32'h2);
    wr(3'd3, 32'h1);
  endtask

  task automatic t_set_wins;
    @(negedge clk); eof = 7'h01; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h100;
    @(negedge clk); eof = '0; reg_wr = 1'b0;
    rd_chk("R11 set wins", 3'd3, 32'h100);
    wr(3'd3, 32'h100);
  endtask

  task automatic t_ctrl;
    fire(7'h0, 7'h0, 7'h0, 7'h0, 7'h0, 5'h1F, 1'b0);
    rd_chk("R12 controller events", 3'd3, 32'h1868);
    wr(3'd3, 32'hFFFFFFFF);
    rd_chk("R6 bit12 sticky", 3'd3, 32'h1000);
  endtask

  task automatic t_map;
    wr(3'd2, 32'hFFFFFFFF);
    rd_chk("R13 pmask width", 3'd2, 32'h3F3F3F3F);
    wr(3'd1, 32'hFFFFFFFF);
    rd_chk("R13 gmask width", 3'd1, 32'h1FFF);
    wr(3'd5, 32'h0);
    rd_chk("R13 intid read only", 3'd5, 32'hA0000006);
    rd_chk("R13 unused address", 3'd7, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_ch0;
    t_lanes;
    t_sint;
    t_ber;
    t_qd;
    t_stop;
    t_set_wins;
    t_ctrl;
    t_map;
    finish_run;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run;
  end
endmodule